// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames on a single TX line. Characters arrive over a valid/ready stream into a holding register. From there they pass into an internal shift register as soon as it is free. One character can therefore wait while another is on the line. When a frame ends and a character is waiting, the next start bit follows the last stop bit with no idle gap. The last character written can always be read back on `hold_q`.

The frame format is set by plain control pins:

- a data length of 7 or 8 bits;
- an optional multiprocessor bit with a chosen value;
- odd, even or no parity;
- one or two stop bits.

The block samples the format when a character loads, so a change takes effect at the next frame. A separate break control holds the line low. When break is released, the line goes high for one full bit time before any further frame.

Bit timing comes from an external tick enable. Each bit lasts 16 ticks, and every state change happens on a tick. Back-pressure rules: `in_ready` is high exactly while the holding register is empty. A character is taken on a rising clock edge where both `in_valid` and `in_ready` are high. `in_valid` may stay high while `in_ready` is low, and nothing is taken in that case. `in_ready` never depends on `in_valid` in the same cycle.

Top module: `sertx_core`

## Requirements
- R1: After reset `tx` is 1, `busy` is 0, `hold_empty` and `in_ready` are 1, and `hold_q` is 0. Whenever `busy` is 0, `tx` is 1.
- R2: `in_ready` equals `hold_empty`. While the holding register is full, `in_valid` has no effect: `hold_q` keeps its value and no extra frame is sent.
- R3: A frame is sent in this order:
  - a start bit at 0;
  - data LSB first, 8 bits when `len8`=1 or the low 7 bits when `len8`=0;
  - the `mp_val` bit, if `mp_en`=1;
  - the parity bit, if enabled;
  - stop bits at 1.
- R4: `par_mode` 2'b01 selects even parity and 2'b10 selects odd parity. 2'b00 and 2'b11 send no parity bit. Parity covers the sent data bits and the multiprocessor bit.
- R5: Each bit lasts exactly 16 cycles in which `tick` is 1. `tx` changes only on a clock edge where `tick` is 1.
- R6: A waiting character moves into the shift register at the first tick while the line is idle. If a character is waiting when a frame's last stop bit ends, its start bit begins at once, with no gap.
- R7: `hold_q` always shows the last character accepted, including after it has moved into the shift register.
- R8: The format controls are sampled when a character loads. Changes made during a frame do not alter that frame.
- R9: When `brk` is 1 at a frame boundary, `tx` goes low and `busy` goes high. Both stay so while `brk` is held. A waiting character is kept in the holding register.
- R10: When `brk` is released, `tx` is high for exactly 16 ticks before the next frame can start.
- R11: `busy` is 1 whenever `tx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Baud tick enable, 16 per bit |
| len8 | input | 1 | 1: eight data bits, 0: seven |
| mp_en | input | 1 | Append multiprocessor bit |
| mp_val | input | 1 | Value of the multiprocessor bit |
| par_mode | input | 2 | 01 even, 10 odd, others none |
| stop2 | input | 1 | 1: two stop bits, 0: one |
| brk | input | 1 | Hold the line low (break) |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character data |
| in_ready | output | 1 | Holding register can take a character |
| hold_q | output | 8 | Last character accepted |
| hold_empty | output | 1 | Holding register empty |
| busy | output | 1 | Frame, break or post-break recovery in progress |
| tx | output | 1 | Serial line |

## Verification
Some properties are checked on every cycle:

- a load never happens without a waiting character;
- the start bit follows a load;
- the line moves only on a tick and stays high whenever the block is not busy;
- a full holding register keeps its contents;
- a held break keeps the block in break.

Other behaviour can only be shown by the bench's scenarios. These are the exact bit order and parity of each format, the zero-gap handoff between frames, format changes within a frame, and the one-bit recovery after a break. The bench decodes the line and compares each frame with frames computed from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_BRK   = 2'd2,
    ST_REST  = 2'd3
  } tx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef struct packed {
    logic       len8;
    logic       mp_en;
    logic       mp_val;
    logic [1:0] par;
    logic       stop2;
  } fmt_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              in_ready,
  output logic              full,
  output logic [DATA_W-1:0] q
);
  logic accept;
  assign in_ready = !full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        q    <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R2: a full holding register keeps its contents until it is taken
  a_r2_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(q)));
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 5,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  fmt_t               fmt,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] pos;
  logic             ones;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    pos      = ONE;
    ones     = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if ((i < DATA_W - 1) || fmt.len8) begin
        frame[pos] = data[i];
        ones       = ones ^ data[i];
        pos        = pos + ONE;
      end
    end
    if (fmt.mp_en) begin
      frame[pos] = fmt.mp_val;
      ones       = ones ^ fmt.mp_val;
      pos        = pos + ONE;
    end
    if (fmt.par == PAR_EVEN) begin
      frame[pos] = ones;
      pos        = pos + ONE;
    end else if (fmt.par == PAR_ODD) begin
      frame[pos] = !ones;
      pos        = pos + ONE;
    end
    nbits = pos + (fmt.stop2 ? TWO : ONE);
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = $clog2(FRAME_W + 1),
  parameter int OVS     = 16,
  localparam int OVS_W  = $clog2(OVS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               brk,
  input  logic               have_data,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  output logic               ld,
  output logic               tx,
  output logic               busy
);
  localparam logic [OVS_W-1:0] TMAX = OVS_W'(OVS - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  tx_state_e          st;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic [OVS_W-1:0]   tcnt;
  logic               bit_end, last_bit, bound;

  assign bit_end  = tick && (tcnt == TMAX);
  assign last_bit = (left == ONE);
  assign bound    = (st == ST_IDLE && tick) ||
                    (st == ST_SHIFT && bit_end && last_bit) ||
                    (st == ST_REST && bit_end);
  assign ld       = bound && !brk && have_data;
  assign tx       = (st == ST_SHIFT) ? sh[0] : (st != ST_BRK);
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else begin
      if (tick && (st == ST_SHIFT || st == ST_REST))
        tcnt <= bit_end ? '0 : tcnt + OVS_W'(1);
      if (st == ST_SHIFT && bit_end && !last_bit) begin
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - ONE;
      end
      if (bound) begin
        if (brk) begin
          st <= ST_BRK;
        end else if (have_data) begin
          st   <= ST_SHIFT;
          sh   <= frame_in;
          left <= nbits_in;
          tcnt <= '0;
        end else begin
          st <= ST_IDLE;
        end
      end else if (st == ST_BRK && tick && !brk) begin
        st   <= ST_REST;
        tcnt <= '0;
      end
    end
  end

  // R9: a break that is still requested keeps the block in break
  a_r9_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BRK && brk) |=> (st == ST_BRK));
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              len8,
  input  logic              mp_en,
  input  logic              mp_val,
  input  logic [1:0]        par_mode,
  input  logic              stop2,
  input  logic              brk,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] hold_q,
  output logic              hold_empty,
  output logic              busy,
  output logic              tx
);
  localparam int FRAME_W = DATA_W + 5;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  fmt_t               fmt;
  logic               hold_full, ld;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign fmt        = '{len8: len8, mp_en: mp_en, mp_val: mp_val, par: par_mode, stop2: stop2};
  assign hold_empty = !hold_full;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .take(ld), .in_ready(in_ready), .full(hold_full), .q(hold_q)
  );

  sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .fmt(fmt), .data(hold_q), .frame(frame), .nbits(nbits)
  );

  sertx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .brk(brk), .have_data(hold_full),
    .frame_in(frame), .nbits_in(nbits), .ld(ld), .tx(tx), .busy(busy)
  );

  // R6: a load only happens when a character is waiting
  a_r6_load_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> hold_full);
  // R3: a load is followed by the low start bit
  a_r3_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !tx);
  // R1: the line is high whenever the block is not busy
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  // R11: a low line implies busy
  a_r11_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !tx |-> busy);
  // R5: the line moves only on a tick
  a_r5_tx_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tx));
endmodule

// File: tb/sim_sertx_core.sv
module sim_sertx_core;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [7:0] d;
    logic       l8;
    logic       mpe;
    logic       mpv;
    logic [1:0] pm;
    logic       s2;
  } ent_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       len8 = 1'b1, mp_en = 1'b0, mp_val = 1'b0, stop2 = 1'b0, brk = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, hold_empty, busy, tx;
  logic [7:0] hold_q;

  int   errs = 0, checks = 0, cyc = 0, tper = 1;
  bit   mon_en = 1'b0, finished = 1'b0;
  ent_t exp_q[$];
  int   starts[$];

  always #(CLK_P/2) clk = !clk;

  sertx_core u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len8(len8), .mp_en(mp_en),
    .mp_val(mp_val), .par_mode(par_mode), .stop2(stop2), .brk(brk),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .hold_q(hold_q), .hold_empty(hold_empty), .busy(busy), .tx(tx)
  );

  initial forever begin @(posedge clk); cyc++; end

  initial begin : tick_gen
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % tper;
      tick = (tc == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  function automatic void build(input ent_t e, output logic [15:0] bits, output int n);
    logic p;
    int dl;
    bits = '1; n = 0; p = 1'b0;
    bits[n] = 1'b0; n++;
    dl = e.l8 ? 8 : 7;
    for (int i = 0; i < dl; i++) begin bits[n] = e.d[i]; p ^= e.d[i]; n++; end
    if (e.mpe) begin bits[n] = e.mpv; p ^= e.mpv; n++; end
    if (e.pm == 2'b01) begin bits[n] = p; n++; end
    if (e.pm == 2'b10) begin bits[n] = !p; n++; end
    bits[n] = 1'b1; n++;
    if (e.s2) begin bits[n] = 1'b1; n++; end
  endfunction

  // line decoder: one check per frame against the expected bits
  initial begin : mon
    ent_t e;
    logic [15:0] eb, gb;
    int n;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && tx === 1'b0) begin
        starts.push_back(cyc);
        if (exp_q.size() == 0) begin
          chk("R3 unexpected start bit", 0, 1);
          while (tx === 1'b0) @(negedge clk);
        end else begin
          e = exp_q.pop_front();
          build(e, eb, n);
          gb = '1;
          repeat (8 * tper) @(negedge clk);
          for (int k = 0; k < n; k++) begin
            gb[k] = tx;
            if (k < n - 1) repeat (16 * tper) @(negedge clk);
          end
          chk("R3 R4 R5 frame bits", {16'h0, gb}, {16'h0, eb});
        end
      end
    end
  end

  task automatic send(input logic [7:0] d);
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back('{d: d, l8: len8, mpe: mp_en, mpv: mp_val, pm: par_mode, s2: stop2});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || !hold_empty);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 0);
    report();
  end

  initial begin : main
    int nch, r0, bad;
    logic [7:0] y;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx after reset", tx, 1);
    chk("R1 busy after reset", busy, 0);
    chk("R1 hold_empty after reset", hold_empty, 1);
    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 hold_q after reset", hold_q, 0);
    repeat (20) @(negedge clk);
    chk("R1 idle line high", tx, 1);
    mon_en = 1'b1;

    // directed 8N1
    send(8'hA5); send(8'h3C); wait_idle();
    chk("R6 queue drained 8N1", exp_q.size(), 0);

    // random formats and tick rates
    for (int b = 0; b < 12; b++) begin
      tper = 1 + $urandom % 3;
      len8 = $urandom % 2; mp_en = $urandom % 2; mp_val = $urandom % 2;
      par_mode = $urandom % 4; stop2 = $urandom % 2;
      nch = 2 + $urandom % 3;
      for (int c = 0; c < nch; c++) send(8'($urandom));
      wait_idle();
      chk("R6 queue drained random", exp_q.size(), 0);
    end

    // R6 back to back with no gap, tick every third cycle
    tper = 3; len8 = 1; mp_en = 0; par_mode = 2'b00; stop2 = 0;
    repeat (6) @(negedge clk);
    starts.delete();
    send(8'h81); send(8'h7E); wait_idle();
    chk("R6 frame count", starts.size(), 2);
    if (starts.size() == 2)
      chk("R6 R5 back-to-back spacing", starts[1] - starts[0], 10 * 16 * 3);

    // R2 writes ignored while full, R7 readback
    tper = 1;
    repeat (4) @(negedge clk);
    send(8'h11); send(8'h22);
    in_valid = 1'b1; in_data = 8'hEE;
    repeat (5) @(negedge clk);
    chk("R2 in_ready low while full", in_ready, 0);
    chk("R2 hold_q kept while full", hold_q, 8'h22);
    in_valid = 1'b0;
    chk("R7 readback during transmission", hold_q, 8'h22);
    wait_idle();
    chk("R2 no extra frame", exp_q.size(), 0);
    chk("R7 readback after transfer", hold_q, 8'h22);

    // R8 format change in mid-frame
    len8 = 1; par_mode = 2'b01; stop2 = 1; mp_en = 1; mp_val = 1;
    send(8'hC3);
    while (!(busy && hold_empty)) @(negedge clk);
    repeat (30) @(negedge clk);
    len8 = 0; par_mode = 2'b00; stop2 = 0; mp_en = 0;
    wait_idle();
    send(8'hFF); wait_idle();
    chk("R8 queue drained after format change", exp_q.size(), 0);

    // R9 break, R10 recovery
    tper = 2; len8 = 1; par_mode = 2'b10; stop2 = 0;
    repeat (6) @(negedge clk);
    mon_en = 1'b0;
    brk = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 tx low in break", tx, 0);
    chk("R9 busy in break", busy, 1);
    y = 8'h5A;
    send(y);
    repeat (6) @(negedge clk);
    chk("R9 character waits during break", hold_empty, 0);
    bad = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (tx !== 1'b0) bad++; end
    chk("R9 line held low", bad, 0);
    brk = 1'b0;
    while (tx !== 1'b1) @(negedge clk);
    r0 = cyc;
    mon_en = 1'b1;
    while (tx !== 1'b0) @(negedge clk);
    chk("R10 high time after break", cyc - r0, 16 * 2);
    wait_idle();
    chk("R9 queued frame sent after break", exp_q.size(), 0);
    chk("R1 idle after all", tx, 1);
    report();
  end
endmodule